// File: doc/BRIEF.md
# Data-Strobe Character Receiver

This block takes the two lines of a data/strobe serial link, oversamples them in the system clock, and turns every change of the exclusive-OR of the two lines into one received bit. The bits are framed into characters whose length follows from the flag bit. A parity bit leads each character. A flag of 0 means eight data bits follow, and a flag of 1 means two control bits follow. Odd parity is checked across character boundaries. An escape pairs with the character after it, and the result is reported as a null, a time code or an escape error.

A link controller and a host read the outputs directly. One pulse marks each decoded character, with a kind code and a byte. Separate one-cycle pulses mark parity errors, escape errors and a disconnect. A level output shows that the first null has arrived. The line inputs are synchronised to the system clock, and all outputs are registered in that domain. A character is therefore seen exactly once.

The framer has three states. `FR_PAR` takes the parity bit and moves to `FR_FLAG`. `FR_FLAG` takes the flag and moves to `FR_BODY`. `FR_BODY` shifts in payload bits and returns to `FR_PAR` on the last one. The decoder has two states. `DC_PLAIN` moves to `DC_ESC` when an escape arrives. `DC_ESC` always returns to `DC_PLAIN` on the next character. A parity error or a disconnect forces both machines back to `FR_PAR` and `DC_PLAIN`.

Top module: `dsrx_char_receiver`

## Requirements
- R1: Each change of (rx_d XOR rx_s) delivers one bit whose value is the current rx_d level. A run of equal bits is carried by strobe toggles alone.
- R2: A character is a parity bit, then a flag bit, then the payload. Flag 0 means 8 data bits, least significant first. Flag 1 means 2 control bits, first bit as the code's LSB. Control codes are FCT=0, EOP=1, EEP=2 and ESC=3.
- R3: The XOR of the previous character's payload bits, the current parity bit and the current flag must be 1. On a mismatch, err_parity pulses and nothing is reported. The first character after reset or after a disconnect is exempt.
- R4: ESC followed by FCT is reported as a null. ESC followed by a data character is reported as a time code carrying that byte.
- R5: ESC followed by EOP, EEP or ESC pulses err_escape and reports no character.
- R6: got_null rises with the first reported null. Before that, no out_valid other than that null is raised, and no parity or escape error is raised.
- R7: Once any line edge has been seen, a quiet period of more than timeout_cycles system clocks pulses err_disconnect. This clears got_null and restarts framing. A shorter gap has no effect.
- R8: During and right after reset, every output is 0.
- R9: out_kind uses these codes: DATA=0, FCT=1, EOP=2, EEP=3, NULL=4, TIME=5.
- R10: A parity error on the character that follows an escape cancels the pair. Only err_parity pulses, and the next data character is reported as plain data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_d | input | 1 | Incoming data line |
| rx_s | input | 1 | Incoming strobe line |
| timeout_cycles | input | TMO_W | Quiet period, in system clocks, before a disconnect |
| out_valid | output | 1 | One-cycle pulse for a decoded character |
| out_kind | output | 3 | Kind code of the decoded character |
| out_data | output | 8 | Byte for data and time-code characters |
| got_null | output | 1 | High once a null has been received |
| err_parity | output | 1 | One-cycle parity error pulse |
| err_escape | output | 1 | One-cycle escape error pulse |
| err_disconnect | output | 1 | One-cycle disconnect pulse |

## Verification
A parity failure and the completion of an escape pair fall on the same character when the character after an escape carries bad parity. The bench provokes this by sending ESC followed by an FCT with its parity bit flipped. It expects err_parity alone, with no null, no escape error and no change to got_null. It then sends a data byte to show that it comes out as plain data rather than as a time code.

// File: rtl/dsrx_pkg.sv
package dsrx_pkg;

    typedef enum logic [2:0] {
        K_DATA = 3'd0,
        K_FCT  = 3'd1,
        K_EOP  = 3'd2,
        K_EEP  = 3'd3,
        K_NULL = 3'd4,
        K_TIME = 3'd5
    } kind_e;

    localparam logic [1:0] C_FCT = 2'd0;
    localparam logic [1:0] C_EOP = 2'd1;
    localparam logic [1:0] C_EEP = 2'd2;
    localparam logic [1:0] C_ESC = 2'd3;

    localparam int DATA_BITS = 8;
    localparam int CTRL_BITS = 2;

    typedef struct packed {
        logic                 is_ctrl;
        logic [DATA_BITS-1:0] payload;
        logic                 par_err;
    } rx_char_t;

endpackage

// File: rtl/dsrx_line_sampler.sv
module dsrx_line_sampler #(
    parameter int TMO_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_d,
    input  logic             rx_s,
    input  logic [TMO_W-1:0] timeout_cycles,
    output logic             bit_stb,
    output logic             bit_val,
    output logic             disc
);

    logic [1:0]       d_sync;
    logic [1:0]       s_sync;
    logic             x_q;
    logic             armed_q;
    logic [TMO_W-1:0] quiet_q;

    // two-stage synchronisers, then edge detection on the XOR
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            d_sync <= '0;
            s_sync <= '0;
            x_q    <= 1'b0;
        end else begin
            d_sync <= {d_sync[0], rx_d};
            s_sync <= {s_sync[0], rx_s};
            x_q    <= d_sync[1] ^ s_sync[1];
        end
    end

    assign bit_stb = (d_sync[1] ^ s_sync[1]) != x_q;
    assign bit_val = d_sync[1];

    // quiet-time counter, armed by the first edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            quiet_q <= '0;
            disc    <= 1'b0;
        end else begin
            disc <= 1'b0;
            if (bit_stb) begin
                armed_q <= 1'b1;
                quiet_q <= '0;
            end else if (armed_q) begin
                if (quiet_q >= timeout_cycles) begin
                    disc    <= 1'b1;
                    armed_q <= 1'b0;
                    quiet_q <= '0;
                end else begin
                    quiet_q <= quiet_q + 1'b1;
                end
            end
        end
    end

    p_disc_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        disc |-> !$past(bit_stb));

    p_disc_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        disc |=> !disc);

endmodule

// File: rtl/dsrx_char_framer.sv
module dsrx_char_framer
    import dsrx_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     bit_stb,
    input  logic     bit_val,
    input  logic     disc,
    output logic     char_stb,
    output rx_char_t char_q
);

    typedef enum logic [1:0] {FR_PAR, FR_FLAG, FR_BODY} fr_state_e;

    localparam logic [3:0] LAST_DATA = 4'(DATA_BITS - 1);
    localparam logic [3:0] LAST_CTRL = 4'(CTRL_BITS - 1);

    fr_state_e            st_q, st_d;
    logic [3:0]           cnt_q;
    logic [DATA_BITS-1:0] sh_q;
    logic                 ctl_q, pbit_q, pok_q, prev_q, first_q;

    logic [3:0]           last_idx;
    logic [DATA_BITS-1:0] sh_nx;
    logic [DATA_BITS-1:0] pay_nx;

    assign last_idx = ctl_q ? LAST_CTRL : LAST_DATA;
    assign sh_nx    = {bit_val, sh_q[DATA_BITS-1:1]};
    assign pay_nx   = ctl_q ? {{(DATA_BITS-CTRL_BITS){1'b0}}, sh_nx[DATA_BITS-1 -: CTRL_BITS]}
                            : sh_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     st_q <= FR_PAR;
        else if (disc)  st_q <= FR_PAR;
        else            st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        if (bit_stb) begin
            unique case (st_q)
                FR_PAR:  st_d = FR_FLAG;
                FR_FLAG: st_d = FR_BODY;
                FR_BODY: if (cnt_q == last_idx) st_d = FR_PAR;
                default: st_d = FR_PAR;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            sh_q     <= '0;
            ctl_q    <= 1'b0;
            pbit_q   <= 1'b0;
            pok_q    <= 1'b0;
            prev_q   <= 1'b0;
            first_q  <= 1'b1;
            char_stb <= 1'b0;
            char_q   <= '0;
        end else begin
            char_stb <= 1'b0;
            if (disc) begin
                cnt_q   <= '0;
                first_q <= 1'b1;
            end else if (bit_stb) begin
                unique case (st_q)
                    FR_PAR: pbit_q <= bit_val;
                    FR_FLAG: begin
                        ctl_q <= bit_val;
                        pok_q <= prev_q ^ pbit_q ^ bit_val;
                        cnt_q <= '0;
                    end
                    FR_BODY: begin
                        sh_q  <= sh_nx;
                        cnt_q <= cnt_q + 1'b1;
                        if (cnt_q == last_idx) begin
                            char_stb       <= 1'b1;
                            char_q.is_ctrl <= ctl_q;
                            char_q.payload <= pay_nx;
                            char_q.par_err <= !first_q && !pok_q;
                            prev_q         <= ^pay_nx;
                            first_q        <= 1'b0;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // a character spans at least four bits, so strobes never touch
    p_stb_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        char_stb |=> !char_stb);

    p_first_exempt_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(disc) |-> !(char_stb && char_q.par_err));

endmodule

// File: rtl/dsrx_char_decoder.sv
module dsrx_char_decoder
    import dsrx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       char_stb,
    input  rx_char_t   char_in,
    input  logic       disc,
    output logic       out_valid,
    output logic [2:0] out_kind,
    output logic [7:0] out_data,
    output logic       got_null,
    output logic       err_parity,
    output logic       err_escape
);

    typedef enum logic {DC_PLAIN, DC_ESC} dc_state_e;

    dc_state_e st_q, st_d;
    logic      e_valid, e_perr, e_eerr;
    kind_e     e_kind;
    logic [7:0] e_data;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     st_q <= DC_PLAIN;
        else if (disc)  st_q <= DC_PLAIN;
        else            st_q <= st_d;
    end

    always_comb begin
        st_d    = st_q;
        e_valid = 1'b0;
        e_perr  = 1'b0;
        e_eerr  = 1'b0;
        e_kind  = K_DATA;
        e_data  = char_in.payload;
        if (char_stb) begin
            if (char_in.par_err) begin
                e_perr = 1'b1;
                st_d   = DC_PLAIN;
            end else begin
                unique case (st_q)
                    DC_PLAIN: begin
                        if (!char_in.is_ctrl) begin
                            e_valid = 1'b1;
                            e_kind  = K_DATA;
                        end else begin
                            unique case (char_in.payload[1:0])
                                C_ESC: st_d = DC_ESC;
                                C_FCT: begin e_valid = 1'b1; e_kind = K_FCT; end
                                C_EOP: begin e_valid = 1'b1; e_kind = K_EOP; end
                                C_EEP: begin e_valid = 1'b1; e_kind = K_EEP; end
                                default: ;
                            endcase
                        end
                    end
                    DC_ESC: begin
                        st_d = DC_PLAIN;
                        if (!char_in.is_ctrl) begin
                            e_valid = 1'b1;
                            e_kind  = K_TIME;
                        end else if (char_in.payload[1:0] == C_FCT) begin
                            e_valid = 1'b1;
                            e_kind  = K_NULL;
                        end else begin
                            e_eerr = 1'b1;
                        end
                    end
                    default: st_d = DC_PLAIN;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_kind   <= K_DATA;
            out_data   <= '0;
            got_null   <= 1'b0;
            err_parity <= 1'b0;
            err_escape <= 1'b0;
        end else if (disc) begin
            out_valid  <= 1'b0;
            got_null   <= 1'b0;
            err_parity <= 1'b0;
            err_escape <= 1'b0;
        end else begin
            out_valid  <= e_valid && (got_null || e_kind == K_NULL);
            err_parity <= e_perr && got_null;
            err_escape <= e_eerr && got_null;
            if (e_valid && e_kind == K_NULL) got_null <= 1'b1;
            if (e_valid) begin
                out_kind <= e_kind;
                out_data <= e_data;
            end
        end
    end

    p_valid_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> got_null);

    p_null_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(got_null) |-> (out_valid && out_kind == K_NULL));

    p_err_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (err_escape || err_parity) |-> !out_valid);

    p_single_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
        err_parity |-> !err_escape);

endmodule

// File: rtl/dsrx_char_receiver.sv
module dsrx_char_receiver
    import dsrx_pkg::*;
#(
    parameter int TMO_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_d,
    input  logic             rx_s,
    input  logic [TMO_W-1:0] timeout_cycles,
    output logic             out_valid,
    output logic [2:0]       out_kind,
    output logic [7:0]       out_data,
    output logic             got_null,
    output logic             err_parity,
    output logic             err_escape,
    output logic             err_disconnect
);

    logic     bit_stb, bit_val, disc;
    logic     char_stb;
    rx_char_t char_q;

    dsrx_line_sampler #(.TMO_W(TMO_W)) u_sampler (
        .clk            (clk),
        .rst_n          (rst_n),
        .rx_d           (rx_d),
        .rx_s           (rx_s),
        .timeout_cycles (timeout_cycles),
        .bit_stb        (bit_stb),
        .bit_val        (bit_val),
        .disc           (disc)
    );

    dsrx_char_framer u_framer (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_stb  (bit_stb),
        .bit_val  (bit_val),
        .disc     (disc),
        .char_stb (char_stb),
        .char_q   (char_q)
    );

    dsrx_char_decoder u_decoder (
        .clk        (clk),
        .rst_n      (rst_n),
        .char_stb   (char_stb),
        .char_in    (char_q),
        .disc       (disc),
        .out_valid  (out_valid),
        .out_kind   (out_kind),
        .out_data   (out_data),
        .got_null   (got_null),
        .err_parity (err_parity),
        .err_escape (err_escape)
    );

    assign err_disconnect = disc;

    p_disc_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err_disconnect |=> !got_null);

endmodule

// File: tb/test_dsrx_char_receiver.sv
`timescale 1ns/1ps
module test_dsrx_char_receiver;

    localparam int HOLD = 4;
    localparam int SETTLE = 8;
    localparam int NVEC = 20;

    typedef struct packed {
        logic       ctl;
        logic [7:0] val;
        logic       badp;
        logic [1:0] expc;   // 0 none, 1 valid, 2 parity err, 3 escape err
        logic [2:0] ekind;
        logic [7:0] edata;
    } vec_t;

    localparam vec_t VEC [NVEC] = '{
        '{1'b1, 8'h00, 1'b0, 2'd0, 3'd0, 8'h00},  // FCT before null
        '{1'b0, 8'h5A, 1'b0, 2'd0, 3'd0, 8'h00},  // data before null
        '{1'b0, 8'h33, 1'b1, 2'd0, 3'd0, 8'h00},  // bad parity before null
        '{1'b1, 8'h03, 1'b0, 2'd0, 3'd0, 8'h00},  // ESC
        '{1'b1, 8'h00, 1'b0, 2'd1, 3'd4, 8'h00},  // FCT -> NULL
        '{1'b0, 8'hA5, 1'b0, 2'd1, 3'd0, 8'hA5},
        '{1'b1, 8'h01, 1'b0, 2'd1, 3'd2, 8'h00},  // EOP
        '{1'b1, 8'h02, 1'b0, 2'd1, 3'd3, 8'h00},  // EEP
        '{1'b1, 8'h00, 1'b0, 2'd1, 3'd1, 8'h00},  // FCT
        '{1'b1, 8'h03, 1'b0, 2'd0, 3'd0, 8'h00},  // ESC
        '{1'b0, 8'h3C, 1'b0, 2'd1, 3'd5, 8'h3C},  // -> TIME
        '{1'b0, 8'h00, 1'b1, 2'd2, 3'd0, 8'h00},  // bad parity
        '{1'b0, 8'hFF, 1'b0, 2'd1, 3'd0, 8'hFF},
        '{1'b1, 8'h03, 1'b0, 2'd0, 3'd0, 8'h00},  // ESC
        '{1'b1, 8'h01, 1'b0, 2'd3, 3'd0, 8'h00},  // EOP -> esc err
        '{1'b1, 8'h03, 1'b0, 2'd0, 3'd0, 8'h00},  // ESC
        '{1'b1, 8'h03, 1'b0, 2'd3, 3'd0, 8'h00},  // ESC -> esc err
        '{1'b1, 8'h03, 1'b0, 2'd0, 3'd0, 8'h00},  // ESC
        '{1'b1, 8'h00, 1'b1, 2'd2, 3'd0, 8'h00},  // FCT bad parity
        '{1'b0, 8'h81, 1'b0, 2'd1, 3'd0, 8'h81}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_d = 1'b0;
    logic       line_s = 1'b0;
    logic [9:0] tmo = 10'd40;
    logic       out_valid, got_null, err_parity, err_escape, err_disconnect;
    logic [2:0] out_kind;
    logic [7:0] out_data;

    int n_checks = 0;
    int n_fail = 0;
    int n_valid = 0, n_perr = 0, n_eerr = 0, n_disc = 0;
    logic [2:0] last_kind = '0;
    logic [7:0] last_data = '0;
    logic prev_par = 1'b0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    dsrx_char_receiver #(.TMO_W(10)) i_dsrx_char_receiver (
        .clk            (clk),
        .rst_n          (rst_n),
        .rx_d           (line_d),
        .rx_s           (line_s),
        .timeout_cycles (tmo),
        .out_valid      (out_valid),
        .out_kind       (out_kind),
        .out_data       (out_data),
        .got_null       (got_null),
        .err_parity     (err_parity),
        .err_escape     (err_escape),
        .err_disconnect (err_disconnect)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid) begin
                n_valid++;
                last_kind = out_kind;
                last_data = out_data;
            end
            if (err_parity)     n_perr++;
            if (err_escape)     n_eerr++;
            if (err_disconnect) n_disc++;
        end
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    // R1: equal consecutive bits toggle the strobe line only
    task automatic send_bit(input logic b);
        if (b != line_d) line_d = b;
        else             line_s = ~line_s;
        repeat (HOLD) step();
    endtask

    task automatic send_char(input logic ctl, input logic [7:0] val, input logic badp);
        int nb;
        logic p;
        nb = ctl ? 2 : 8;
        p  = ~(prev_par ^ ctl) ^ badp;
        send_bit(p);
        send_bit(ctl);
        for (int k = 0; k < nb; k++) send_bit(val[k]);
        prev_par = ctl ? ^val[1:0] : ^val;
    endtask

    function automatic string tag_of(input int i);
        case (i)
            0, 1, 2:        return "R6";
            3, 4, 9, 10:    return "R4";
            5:              return "R2";
            6, 7, 8:        return "R9";
            11:             return "R3";
            12:             return "R1";
            13, 14, 15, 16: return "R5";
            default:        return "R10";
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        int v0, p0, e0, d0, act, exp;
        repeat (3) step();
        // R8: reset state
        check({out_valid, out_kind, out_data, got_null, err_parity, err_escape, err_disconnect} == '0,
              "R8", "outputs in reset", int'(out_data), 0);
        rst_n = 1'b1;
        repeat (3) step();
        check({out_valid, out_kind, out_data, got_null, err_parity, err_escape, err_disconnect} == '0,
              "R8", "outputs after reset", int'(got_null), 0);

        for (int i = 0; i < NVEC; i++) begin
            v0 = n_valid; p0 = n_perr; e0 = n_eerr;
            send_char(VEC[i].ctl, VEC[i].val, VEC[i].badp);
            repeat (SETTLE) step();
            act = (n_valid - v0) * 100 + (n_perr - p0) * 10 + (n_eerr - e0);
            case (VEC[i].expc)
                2'd1:    exp = 100;
                2'd2:    exp = 10;
                2'd3:    exp = 1;
                default: exp = 0;
            endcase
            check(act == exp, tag_of(i), $sformatf("vector %0d event code", i), act, exp);
            if (VEC[i].expc == 2'd1) begin
                check(last_kind == VEC[i].ekind, "R9", $sformatf("vector %0d kind", i),
                      int'(last_kind), int'(VEC[i].ekind));
                if (VEC[i].ekind == 3'd0 || VEC[i].ekind == 3'd5)
                    check(last_data == VEC[i].edata, "R2", $sformatf("vector %0d byte", i),
                          int'(last_data), int'(VEC[i].edata));
            end
            if (i == 4)
                check(got_null == 1'b1, "R6", "got_null after first null", int'(got_null), 1);
        end

        // R7: gap below the timeout leaves the link alone
        d0 = n_disc;
        repeat (20) step();
        check(n_disc == d0 && got_null, "R7", "short gap disconnects", n_disc - d0, 0);

        // R7: long gap raises a disconnect and clears got_null
        send_char(1'b1, 8'h00, 1'b0);
        repeat (80) step();
        check(n_disc - d0 == 1, "R7", "long gap disconnect count", n_disc - d0, 1);
        check(got_null == 1'b0, "R7", "got_null after disconnect", int'(got_null), 0);

        // R3: first character after a disconnect is exempt from parity
        v0 = n_valid;
        send_char(1'b1, 8'h03, 1'b1);
        send_char(1'b1, 8'h00, 1'b0);
        repeat (SETTLE) step();
        check(n_valid - v0 == 1 && last_kind == 3'd4, "R3", "exempt ESC then FCT gives null",
              int'(last_kind), 4);
        check(got_null == 1'b1, "R6", "got_null restored", int'(got_null), 1);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule